// File: doc/BRIEF.md
# Widening Multiply-Accumulate Lane With Per-Operand Signedness

This block is one lane of a vector multiply unit. It takes two 8-bit operands, reads each of them as signed or unsigned according to its own control bit, forms the exact product and widens it to 24 bits. A second control picks what happens to that product. It can be returned alone, added to a 24-bit accumulator value supplied with the operands, or subtracted from that value. All arithmetic wraps modulo 2^24 and never saturates.

Each operation is qualified by a valid strobe. The result sits in a register that loads only on a valid cycle, so the output is stable between operations. A companion valid output marks the cycle in which a new result is visible. The instantiating design replicates the lane as many times as it needs and feeds each copy its own operands and accumulator value.

Top module: `mac_lane`

## Requirements
- R1: While `rst` is high at a rising clock edge, `res_o` becomes 0 and `vld_o` becomes 0 after that edge.
- R2: `vld_o` is high in the cycle after each rising edge at which `vld_i` is high, and low in the cycle after each edge at which `vld_i` is low. A new `res_o` appears in that same cycle.
- R3: When `vld_i` is low at a rising edge, `res_o` keeps its value, whatever the other inputs are.
- R4: `sgn_i[0]` set makes A a two's-complement value, and clear makes it unsigned. `sgn_i[1]` does the same for B. With both set, 0x7F×0x7F gives 0x003F01 and 0xFF×0x02 gives 0xFFFFFE.
- R5: With `sgn_i` = 2'b00 (both unsigned), 0xFF×0x02 gives 0x0001FE. A product of two unsigned operands never sets bits 23:16.
- R6: In the mixed codes, 2'b10 (A unsigned, B signed) turns 0xFF×0xFF into 255×(-1) = 0xFFFF01. The code 2'b01 (A signed, B unsigned) turns the same operands into (-1)×255 = 0xFFFF01, and turns 0xFF×0x02 into 0xFFFFFE.
- R7: With `op_i` = 0, `res_o` is the product sign-extended to 24 bits, and `acc_i` has no effect.
- R8: With `op_i` = 1, `res_o` = (`acc_i` + product) mod 2^24. For example, 0xFFFFFF + 1×1 gives 0x000000.
- R9: With `op_i` = 2, `res_o` = (`acc_i` − product) mod 2^24. For example, 0x000000 − 1×1 gives 0xFFFFFF.
- R10: `op_i` = 3 behaves exactly like `op_i` = 0, and `acc_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| vld_i | input | 1 | Qualifies the operands and controls in this cycle |
| sgn_i | input | 2 | Bit 0: A is signed; bit 1: B is signed |
| op_i | input | 2 | 0 multiply, 1 multiply-add, 2 multiply-subtract, 3 multiply |
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B |
| acc_i | input | 24 | Accumulator value for the add and subtract forms |
| res_o | output | 24 | Registered 24-bit result |
| vld_o | output | 1 | High in the cycle a new result is presented |

## Verification
The bench aims at the places where the signedness and widening can go wrong. It uses 0xFF operands in every signedness code, because an extension stage with swapped or shared sign bits gives 0x00FE01 where 0xFFFF01 is expected, or the reverse. It drives accumulate and subtract across the 2^24 boundary. A datapath that saturates or drops the carry-in of the subtract returns 0xFFFFFF instead of 0, or misses the result by one. It also changes every input while the strobe is low and checks that the result register holds and the valid output stays low. A lane that loads on every cycle fails this test. A pseudo-random sweep then compares every mode and operation against a reference model written from the requirements.

// File: rtl/mac_lane_pkg.sv
package mac_lane_pkg;
  // Post-multiply operation select; the encoding is behaviour (see R7..R10)
  typedef enum logic [1:0] {
    OP_MUL  = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2,
    OP_MUL2 = 2'd3
  } mac_op_e;
endpackage

// File: rtl/operand_ext.sv
// Widens one operand by a single bit, as a sign or a zero, chosen per operand.
module operand_ext #(
  parameter int W = 8
) (
  input  logic [W-1:0]      d,
  input  logic              is_signed,
  output logic signed [W:0] q
);
  logic top_bit;
  always_comb begin
    top_bit = is_signed & d[W-1];
    q       = $signed({top_bit, d});
  end
endmodule

// File: rtl/mul_core.sv
// Signed multiply of two pre-extended operands, fitted to the result width.
module mul_core #(
  parameter int AW = 8,
  parameter int BW = 8,
  parameter int RW = 24
) (
  input  logic signed [AW:0] a,
  input  logic signed [BW:0] b,
  output logic [RW-1:0]      p
);
  localparam int PW = AW + BW + 2;

  logic signed [PW-1:0] full;
  always_comb full = a * b;

  generate
    if (RW > PW) begin : g_widen
      assign p = {{(RW-PW){full[PW-1]}}, full};
    end else if (RW == PW) begin : g_exact
      assign p = full;
    end else begin : g_trunc
      assign p = full[RW-1:0];
    end
  endgenerate
endmodule

// File: rtl/acc_unit.sv
// One adder serves plain multiply, accumulate and subtract.
module acc_unit
  import mac_lane_pkg::*;
#(
  parameter int W = 24
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] prod,
  input  mac_op_e      op,
  output logic [W-1:0] sum
);
  logic          subtract;
  logic          use_acc;
  logic [W-1:0]  base;
  logic [W-1:0]  addend;
  logic [W-1:0]  carry_in;

  always_comb begin
    subtract = (op == OP_SUB);
    use_acc  = (op == OP_ADD) || (op == OP_SUB);
    base     = use_acc ? acc : '0;
    addend   = subtract ? ~prod : prod;
    carry_in = {{(W-1){1'b0}}, subtract};
    sum      = base + addend + carry_in;
  end
endmodule

// File: rtl/mac_lane.sv
module mac_lane
  import mac_lane_pkg::*;
#(
  parameter int A_W   = 8,
  parameter int B_W   = 8,
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_i,
  input  logic [1:0]       sgn_i,
  input  logic [1:0]       op_i,
  input  logic [A_W-1:0]   a_i,
  input  logic [B_W-1:0]   b_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic [ACC_W-1:0] res_o,
  output logic             vld_o
);
  logic signed [A_W:0] a_ext;
  logic signed [B_W:0] b_ext;
  logic [ACC_W-1:0]    prod;
  logic [ACC_W-1:0]    next_res;
  mac_op_e             op_sel;

  always_comb op_sel = mac_op_e'(op_i);

  operand_ext #(.W(A_W)) u_ext_a (.d(a_i), .is_signed(sgn_i[0]), .q(a_ext));
  operand_ext #(.W(B_W)) u_ext_b (.d(b_i), .is_signed(sgn_i[1]), .q(b_ext));

  mul_core #(.AW(A_W), .BW(B_W), .RW(ACC_W)) u_mul (
    .a(a_ext), .b(b_ext), .p(prod)
  );

  acc_unit #(.W(ACC_W)) u_acc (
    .acc(acc_i), .prod(prod), .op(op_sel), .sum(next_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) res_o <= next_res;
    end
  end
endmodule

// File: rtl/mac_lane_chk.sv
module mac_lane_chk #(
  parameter int A_W   = 8,
  parameter int B_W   = 8,
  parameter int ACC_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             vld_i,
  input logic [1:0]       sgn_i,
  input logic [1:0]       op_i,
  input logic [A_W-1:0]   a_i,
  input logic [B_W-1:0]   b_i,
  input logic [ACC_W-1:0] acc_i,
  input logic [ACC_W-1:0] res_o,
  input logic             vld_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (res_o == '0 && !vld_o));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    vld_i |=> vld_o);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> !vld_o);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> $stable(res_o));

  // R5
  unsigned_range_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_i && sgn_i == 2'b00 && op_i == 2'd0) |=> res_o[ACC_W-1:A_W+B_W] == '0);

  // R7
  zero_product_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_i && op_i == 2'd0 && a_i == '0) |=> res_o == '0);

  // R8
  add_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_i && op_i == 2'd1 && b_i == '0) |=> res_o == $past(acc_i));

  // R9
  sub_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_i && op_i == 2'd2 && a_i == '0) |=> res_o == $past(acc_i));
endmodule

bind mac_lane mac_lane_chk #(.A_W(A_W), .B_W(B_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .vld_i(vld_i), .sgn_i(sgn_i), .op_i(op_i),
  .a_i(a_i), .b_i(b_i), .acc_i(acc_i), .res_o(res_o), .vld_o(vld_o)
);

// File: tb/sim_mac_lane.sv
module sim_mac_lane;
  logic        clk = 1'b0;
  logic        rst;
  logic        vld_i;
  logic [1:0]  sgn_i;
  logic [1:0]  op_i;
  logic [7:0]  a_i;
  logic [7:0]  b_i;
  logic [23:0] acc_i;
  logic [23:0] res_o;
  logic        vld_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  mac_lane u0 (
    .clk(clk), .rst(rst), .vld_i(vld_i), .sgn_i(sgn_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .acc_i(acc_i), .res_o(res_o), .vld_o(vld_o)
  );

  function automatic logic [23:0] model(input logic [1:0] m, input logic [1:0] op,
                                        input logic [7:0] a, input logic [7:0] b,
                                        input logic [23:0] acc);
    int sa;
    int sb;
    int p;
    int r;
    sa = m[0] ? int'($signed(a)) : int'(a);
    sb = m[1] ? int'($signed(b)) : int'(b);
    p  = sa * sb;
    case (op)
      2'd1:    r = int'(acc) + p;
      2'd2:    r = int'(acc) - p;
      default: r = p;
    endcase
    return r[23:0];
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%06h expected 0x%06h", req, act, exp);
    end
  endtask

  // Drive one valid operation at a falling edge, sample at the next falling edge
  task automatic run_op(input string req, input logic [1:0] m, input logic [1:0] op,
                        input logic [7:0] a, input logic [7:0] b,
                        input logic [23:0] acc, input logic [23:0] exp);
    vld_i = 1'b1; sgn_i = m; op_i = op; a_i = a; b_i = b; acc_i = acc;
    @(negedge clk);
    vld_i = 1'b0;
    check(req, res_o, exp);
    check("R2 vld_o", {23'd0, vld_o}, 24'd1);
  endtask

  task automatic t_reset;
    rst = 1'b1; vld_i = 1'b1; sgn_i = 2'b11; op_i = 2'd1;
    a_i = 8'h55; b_i = 8'h33; acc_i = 24'h123456;
    repeat (3) @(negedge clk);
    check("R1 res_o", res_o, 24'd0);
    check("R1 vld_o", {23'd0, vld_o}, 24'd0);
    rst = 1'b0; vld_i = 1'b0;
    @(negedge clk);
    check("R2 idle vld_o", {23'd0, vld_o}, 24'd0);
  endtask

  task automatic t_signed;
    run_op("R4 7F*7F", 2'b11, 2'd0, 8'h7F, 8'h7F, 24'h0, 24'h003F01);
    run_op("R4 FF*02", 2'b11, 2'd0, 8'hFF, 8'h02, 24'h0, 24'hFFFFFE);
    run_op("R4 80*80", 2'b11, 2'd0, 8'h80, 8'h80, 24'h0, 24'h004000);
  endtask

  task automatic t_unsigned;
    run_op("R5 FF*02", 2'b00, 2'd0, 8'hFF, 8'h02, 24'h0, 24'h0001FE);
    run_op("R5 FF*FF", 2'b00, 2'd0, 8'hFF, 8'hFF, 24'h0, 24'h00FE01);
  endtask

  task automatic t_mixed;
    run_op("R6 uA sB FF*FF", 2'b10, 2'd0, 8'hFF, 8'hFF, 24'h0, 24'hFFFF01);
    run_op("R6 sA uB FF*FF", 2'b01, 2'd0, 8'hFF, 8'hFF, 24'h0, 24'hFFFF01);
    run_op("R6 sA uB FF*02", 2'b01, 2'd0, 8'hFF, 8'h02, 24'h0, 24'hFFFFFE);
    run_op("R6 uA sB FF*02", 2'b10, 2'd0, 8'hFF, 8'h02, 24'h0, 24'h0001FE);
  endtask

  task automatic t_ops;
    run_op("R7 acc ignored", 2'b11, 2'd0, 8'h03, 8'h05, 24'hABCDEF, 24'h00000F);
    run_op("R8 wrap", 2'b11, 2'd1, 8'h01, 8'h01, 24'hFFFFFF, 24'h000000);
    run_op("R8 neg prod", 2'b11, 2'd1, 8'hFF, 8'h02, 24'h000010, 24'h00000E);
    run_op("R9 wrap", 2'b11, 2'd2, 8'h01, 8'h01, 24'h000000, 24'hFFFFFF);
    run_op("R9 neg prod", 2'b11, 2'd2, 8'hFF, 8'h02, 24'h000010, 24'h000012);
    run_op("R9 unsigned", 2'b00, 2'd2, 8'hFF, 8'hFF, 24'h010000, 24'h0001FF);
    run_op("R10 op3", 2'b11, 2'd3, 8'hFF, 8'h02, 24'h777777, 24'hFFFFFE);
  endtask

  task automatic t_hold;
    logic [23:0] kept;
    run_op("R3 setup", 2'b00, 2'd1, 8'h10, 8'h10, 24'h000001, 24'h000101);
    kept = res_o;
    for (int i = 0; i < 4; i++) begin
      sgn_i = 2'(i); op_i = 2'(i); a_i = 8'(8'hA5 + i); b_i = 8'(8'h3C - i);
      acc_i = 24'(24'h800000 + i);
      @(negedge clk);
      check("R3 hold", res_o, kept);
      check("R3 vld_o low", {23'd0, vld_o}, 24'd0);
    end
  endtask

  task automatic t_sweep;
    logic [31:0] lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 400; i++) begin
      logic [1:0]  m;
      logic [1:0]  op;
      logic [7:0]  a;
      logic [7:0]  b;
      logic [23:0] acc;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      m = lfsr[1:0]; op = lfsr[3:2]; a = lfsr[11:4]; b = lfsr[19:12];
      acc = {lfsr[31:20], lfsr[11:0]};
      run_op("R4-sweep R7 R8 R9", m, op, a, b, acc, model(m, op, a, b, acc));
    end
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_signed();
    t_unsigned();
    t_mixed();
    t_ops();
    t_hold();
    t_sweep();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule